// File: doc/BRIEF.md
# Flash Sector Protection Guard

This block decides whether write-type operations on a sectored NOR-style flash array may proceed. It holds one protection flag per sector and judges program, erase, protect and unprotect strobes against those flags. The judgement also takes account of a high-voltage override input and a low-supply inhibit input. Each judged strobe produces a one-cycle grant or deny pulse. A granted program or erase then holds the ready output low for a fixed busy interval, which stands in for the embedded algorithm.

A separate query strobe returns the protection state of the addressed sector as an 8-bit status code. The sector is chosen by the high-order address bits, which arrive on their own port.

Two resets are modelled:

- The power-on reset clears every protection flag.
- The device reset aborts a running operation and keeps the part busy for a fixed interval. Queries are then refused for a recovery interval after the device reset is released.

Top module: `flash_sector_guard`

## Requirements
- R1: After power-on reset every sector reads as unprotected. Ready is high, and grant, deny and status-valid are low.
- R2: A program or erase to a sector that is not protected, made while idle, gives a grant pulse one cycle after the strobe. Ready then goes low in that same cycle and stays low for exactly OP_CYC cycles.
- R3: A program or erase to a protected sector, with the high-voltage input low, gives a deny pulse one cycle after the strobe. Ready stays high.
- R4: A protect request is always granted when it is judged. The sector reads as protected from the next cycle on. A query made in the same cycle as the protect request reports the state before the change.
- R5: An unprotect request is granted, and clears the addressed sector's flag, only when all sectors are protected. Otherwise it is denied and no flag changes.
- R6: While the high-voltage input is high, program and erase to protected sectors are granted and no stored flag is altered. Once the input is low again, those sectors deny program and erase.
- R7: While the low-supply input is high, no program, erase, protect or unprotect strobe produces a grant or deny pulse, starts a busy interval or changes a flag.
- R8: A query pulses status-valid one cycle after the strobe. The status is 8'h01 for a protected sector and 8'h00 for an unprotected one.
- R9: Any write-type strobe judged while ready is low is denied and has no other effect.
- R10: If the device reset is sampled while a program or erase is running, the operation is aborted and ready stays low for exactly RST_BUSY_CYC cycles after that edge. If the device reset is sampled while idle, ready stays high. Write-type strobes sampled with the device reset high are ignored.
- R11: Queries are refused while the device reset is high and at each of the READ_RECOVER_CYC clock edges after its release. A refused query gives status-valid low and status 8'h00. A query at the next edge after that window is answered.
- R12: When several write-type strobes arrive together, only one is judged, in the priority order program, erase, protect, unprotect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low; clears all protection flags |
| dev_rst_i | input | 1 | Synchronous device reset, active high |
| sec_addr_i | input | SEC_W | High-order address bits selecting the sector |
| prog_req_i | input | 1 | Program request strobe |
| erase_req_i | input | 1 | Erase request strobe |
| prot_req_i | input | 1 | Protect request strobe |
| unprot_req_i | input | 1 | Permanent unprotect request strobe |
| query_req_i | input | 1 | Protection status query strobe |
| hv_i | input | 1 | High-voltage present; temporarily overrides protection |
| vlow_i | input | 1 | Supply below lockout level; inhibits write-type requests |
| grant_o | output | 1 | One-cycle grant pulse |
| deny_o | output | 1 | One-cycle deny pulse |
| ready_o | output | 1 | High when no operation or reset interval is running |
| stat_o | output | 8 | Protection status code of the queried sector |
| stat_vld_o | output | 1 | One-cycle pulse marking stat_o valid |

## Verification
A protect request and a status query to the same sector can be sampled on the same clock edge. One changes the flag and the other reads it. The bench strobes both together on a sector that is not protected. It expects a grant pulse together with a status of 8'h00, which is the old state. A lone query on the following cycle must then return 8'h01.

// File: rtl/fsg_pkg.sv
package fsg_pkg;
   typedef enum logic [2:0] {
      OP_NONE   = 3'd0,
      OP_PROG   = 3'd1,
      OP_ERASE  = 3'd2,
      OP_PROT   = 3'd3,
      OP_UNPROT = 3'd4
   } fsg_op_e;

   localparam logic [7:0] STAT_PROTECTED   = 8'h01;
   localparam logic [7:0] STAT_UNPROTECTED = 8'h00;
endpackage

// File: rtl/fsg_prot_bank.sv
module fsg_prot_bank #(
   parameter int NUM_SECTORS = 8,
   localparam int SEC_W = $clog2(NUM_SECTORS)
) (
   input  logic                   clk,
   input  logic                   por_n,
   input  logic                   set_en_i,
   input  logic                   clr_en_i,
   input  logic [SEC_W-1:0]       sel_i,
   output logic [NUM_SECTORS-1:0] bits_o,
   output logic                   all_prot_o
);
   for (genvar s = 0; s < NUM_SECTORS; s++) begin : g_sector
      always_ff @(posedge clk or negedge por_n) begin
         if (!por_n)
            bits_o[s] <= 1'b0;
         else if (set_en_i && (sel_i == SEC_W'(s)))
            bits_o[s] <= 1'b1;
         else if (clr_en_i && (sel_i == SEC_W'(s)))
            bits_o[s] <= 1'b0;
      end
   end

   assign all_prot_o = &bits_o;

   AST_BITS_HELD: assert property (@(posedge clk) disable iff (!por_n)
      !$past(set_en_i || clr_en_i) |-> $stable(bits_o)); // R6
   AST_SET_TAKES: assert property (@(posedge clk) disable iff (!por_n)
      $past(set_en_i) |-> bits_o[$past(sel_i)]); // R4
endmodule

// File: rtl/fsg_busy_timer.sv
module fsg_busy_timer #(
   parameter int OP_CYC       = 5,
   parameter int RST_BUSY_CYC = 6,
   localparam int OPC_W = $clog2(OP_CYC + 1),
   localparam int RBC_W = $clog2(RST_BUSY_CYC + 1)
) (
   input  logic clk,
   input  logic por_n,
   input  logic start_i,
   input  logic dev_rst_i,
   output logic busy_o
);
   logic [OPC_W-1:0] op_cnt;
   logic             op_active;
   logic             rst_busy;

   assign op_active = (op_cnt != '0);

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)
         op_cnt <= '0;
      else if (dev_rst_i)
         op_cnt <= '0;
      else if (start_i)
         op_cnt <= OPC_W'(OP_CYC);
      else if (op_active)
         op_cnt <= op_cnt - 1'b1;
   end

   if (RST_BUSY_CYC > 0) begin : g_rst_hold
      logic [RBC_W-1:0] rb_cnt;
      always_ff @(posedge clk or negedge por_n) begin
         if (!por_n)
            rb_cnt <= '0;
         else if (dev_rst_i && op_active)
            rb_cnt <= RBC_W'(RST_BUSY_CYC);
         else if (rb_cnt != '0)
            rb_cnt <= rb_cnt - 1'b1;
      end
      assign rst_busy = (rb_cnt != '0);

      AST_RST_HOLDS_BUSY: assert property (@(posedge clk) disable iff (!por_n)
         $past(dev_rst_i && op_active) |-> busy_o); // R10
   end else begin : g_no_rst_hold
      assign rst_busy = 1'b0;
   end

   assign busy_o = op_active || rst_busy;

   AST_OP_HOLDS_BUSY: assert property (@(posedge clk) disable iff (!por_n)
      $past(start_i) |-> busy_o); // R2
endmodule

// File: rtl/fsg_read_gate.sv
module fsg_read_gate #(
   parameter int READ_RECOVER_CYC = 4,
   localparam int RRC_W = $clog2(READ_RECOVER_CYC + 1)
) (
   input  logic clk,
   input  logic por_n,
   input  logic dev_rst_i,
   output logic open_o
);
   if (READ_RECOVER_CYC > 0) begin : g_recover
      logic [RRC_W-1:0] rec_cnt;
      always_ff @(posedge clk or negedge por_n) begin
         if (!por_n)
            rec_cnt <= '0;
         else if (dev_rst_i)
            rec_cnt <= RRC_W'(READ_RECOVER_CYC);
         else if (rec_cnt != '0)
            rec_cnt <= rec_cnt - 1'b1;
      end
      assign open_o = !dev_rst_i && (rec_cnt == '0);

      AST_GATE_SHUT_AFTER_RST: assert property (@(posedge clk) disable iff (!por_n)
         $past(dev_rst_i) |-> !open_o); // R11
   end else begin : g_direct
      assign open_o = !dev_rst_i;
   end
endmodule

// File: rtl/flash_sector_guard.sv
module flash_sector_guard
   import fsg_pkg::*;
#(
   parameter int NUM_SECTORS      = 8,
   parameter int OP_CYC           = 5,
   parameter int RST_BUSY_CYC     = 6,
   parameter int READ_RECOVER_CYC = 4,
   localparam int SEC_W = $clog2(NUM_SECTORS)
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic             dev_rst_i,
   input  logic [SEC_W-1:0] sec_addr_i,
   input  logic             prog_req_i,
   input  logic             erase_req_i,
   input  logic             prot_req_i,
   input  logic             unprot_req_i,
   input  logic             query_req_i,
   input  logic             hv_i,
   input  logic             vlow_i,
   output logic             grant_o,
   output logic             deny_o,
   output logic             ready_o,
   output logic [7:0]       stat_o,
   output logic             stat_vld_o
);
   if (NUM_SECTORS < 2 || (NUM_SECTORS & (NUM_SECTORS - 1)) != 0) begin : g_bad_sectors
      $error("NUM_SECTORS must be a power of two, at least 2");
   end
   if (OP_CYC < 1) begin : g_bad_opcyc
      $error("OP_CYC must be at least 1");
   end
   if (RST_BUSY_CYC < 0 || READ_RECOVER_CYC < 0) begin : g_bad_intervals
      $error("interval parameters must not be negative");
   end

   logic [NUM_SECTORS-1:0] prot_bits;
   logic                   all_prot;
   logic                   busy;
   logic                   read_open;
   fsg_op_e                op_sel, op_q;
   logic                   live, sec_prot, any_write;
   logic                   do_grant, do_deny, start_op, set_en, clr_en;
   logic                   q_ok;

   // priority encode: program > erase > protect > unprotect (R12)
   always_comb begin
      if (prog_req_i)        op_sel = OP_PROG;
      else if (erase_req_i)  op_sel = OP_ERASE;
      else if (prot_req_i)   op_sel = OP_PROT;
      else if (unprot_req_i) op_sel = OP_UNPROT;
      else                   op_sel = OP_NONE;
   end

   assign any_write = (op_sel != OP_NONE);
   assign live      = any_write && !vlow_i && !dev_rst_i;
   assign sec_prot  = prot_bits[sec_addr_i];

   always_comb begin
      do_grant = 1'b0;
      do_deny  = 1'b0;
      start_op = 1'b0;
      set_en   = 1'b0;
      clr_en   = 1'b0;
      if (live) begin
         if (busy) begin
            do_deny = 1'b1;
         end else begin
            case (op_sel)
               OP_PROG, OP_ERASE: begin
                  if (sec_prot && !hv_i) begin
                     do_deny = 1'b1;
                  end else begin
                     do_grant = 1'b1;
                     start_op = 1'b1;
                  end
               end
               OP_PROT: begin
                  do_grant = 1'b1;
                  set_en   = 1'b1;
               end
               OP_UNPROT: begin
                  if (all_prot) begin
                     do_grant = 1'b1;
                     clr_en   = 1'b1;
                  end else begin
                     do_deny = 1'b1;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   fsg_prot_bank #(.NUM_SECTORS(NUM_SECTORS)) u_bank (
      .clk        (clk),
      .por_n      (por_n),
      .set_en_i   (set_en),
      .clr_en_i   (clr_en),
      .sel_i      (sec_addr_i),
      .bits_o     (prot_bits),
      .all_prot_o (all_prot)
   );

   fsg_busy_timer #(.OP_CYC(OP_CYC), .RST_BUSY_CYC(RST_BUSY_CYC)) u_timer (
      .clk       (clk),
      .por_n     (por_n),
      .start_i   (start_op),
      .dev_rst_i (dev_rst_i),
      .busy_o    (busy)
   );

   fsg_read_gate #(.READ_RECOVER_CYC(READ_RECOVER_CYC)) u_gate (
      .clk       (clk),
      .por_n     (por_n),
      .dev_rst_i (dev_rst_i),
      .open_o    (read_open)
   );

   assign ready_o = !busy;
   assign q_ok    = query_req_i && read_open;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         grant_o    <= 1'b0;
         deny_o     <= 1'b0;
         op_q       <= OP_NONE;
         stat_vld_o <= 1'b0;
         stat_o     <= STAT_UNPROTECTED;
      end else begin
         grant_o    <= do_grant;
         deny_o     <= do_deny;
         op_q       <= live ? op_sel : OP_NONE;
         stat_vld_o <= q_ok;
         stat_o     <= (q_ok && sec_prot) ? STAT_PROTECTED : STAT_UNPROTECTED;
      end
   end

   AST_PROT_BLOCKS: assert property (@(posedge clk) disable iff (!por_n)
      (grant_o && (op_q == OP_PROG || op_q == OP_ERASE))
         |-> (!$past(prot_bits[sec_addr_i]) || $past(hv_i))); // R3
   AST_UNPROT_NEEDS_ALL: assert property (@(posedge clk) disable iff (!por_n)
      (grant_o && op_q == OP_UNPROT) |-> $past(all_prot)); // R5
   AST_VLOW_SILENT: assert property (@(posedge clk) disable iff (!por_n)
      $past(vlow_i) |-> !(grant_o || deny_o)); // R7
   AST_NO_READ_IN_RST: assert property (@(posedge clk) disable iff (!por_n)
      $past(dev_rst_i) |-> !stat_vld_o); // R11
   AST_STAT_CODE: assert property (@(posedge clk) disable iff (!por_n)
      stat_vld_o |-> (stat_o[7:1] == 7'd0)); // R8
   AST_BUSY_DENIES: assert property (@(posedge clk) disable iff (!por_n)
      $past(busy && live) |-> (deny_o && !grant_o)); // R9
endmodule

// File: tb/sim_flash_sector_guard.sv
module sim_flash_sector_guard;
   localparam int NS = 8;
   localparam int OPC = 5;
   localparam int RBC = 6;
   localparam int RRC = 4;

   // bench op codes
   localparam logic [2:0] K_NONE = 3'd0, K_PROG = 3'd1, K_ERASE = 3'd2,
                          K_PROT = 3'd3, K_UNPROT = 3'd4, K_QUERY = 3'd5;

   logic       clk = 1'b0;
   logic       por_n = 1'b0;
   logic       dev_rst = 1'b0;
   logic [2:0] sec = 3'd0;
   logic       prog = 1'b0, erase = 1'b0, prot = 1'b0, unprot = 1'b0, query = 1'b0;
   logic       hv = 1'b0, vlow = 1'b0;
   logic       grant, deny, ready, svld;
   logic [7:0] stat;

   int nchk = 0;
   int nerr = 0;

   always #2.5ns clk = ~clk;

   flash_sector_guard #(
      .NUM_SECTORS(NS), .OP_CYC(OPC), .RST_BUSY_CYC(RBC), .READ_RECOVER_CYC(RRC)
   ) u0 (
      .clk(clk), .por_n(por_n), .dev_rst_i(dev_rst), .sec_addr_i(sec),
      .prog_req_i(prog), .erase_req_i(erase), .prot_req_i(prot),
      .unprot_req_i(unprot), .query_req_i(query), .hv_i(hv), .vlow_i(vlow),
      .grant_o(grant), .deny_o(deny), .ready_o(ready), .stat_o(stat),
      .stat_vld_o(svld)
   );

   // entry: op[15:13] sec[12:10] hv[9] vlow[8] grant[7] deny[6] valid[5] prot[4] req[3:0]
   function automatic logic [15:0] vec(input logic [2:0] op, input logic [2:0] s,
                                      input logic h, input logic v, input logic g,
                                      input logic d, input logic q, input logic p,
                                      input logic [3:0] r);
      return {op, s, h, v, g, d, q, p, r};
   endfunction

   localparam int NV = 34;
   localparam logic [15:0] VT [NV] = '{
      vec(K_QUERY, 3'd3, 0, 0, 0, 0, 1, 0, 4'd1),   // R1
      vec(K_QUERY, 3'd7, 0, 0, 0, 0, 1, 0, 4'd1),   // R1
      vec(K_PROG,  3'd3, 0, 0, 1, 0, 0, 0, 4'd2),   // R2
      vec(K_ERASE, 3'd5, 0, 0, 1, 0, 0, 0, 4'd2),   // R2
      vec(K_PROT,  3'd3, 0, 0, 1, 0, 0, 0, 4'd4),   // R4
      vec(K_QUERY, 3'd3, 0, 0, 0, 0, 1, 1, 4'd8),   // R8
      vec(K_QUERY, 3'd4, 0, 0, 0, 0, 1, 0, 4'd8),   // R8
      vec(K_PROG,  3'd3, 0, 0, 0, 1, 0, 0, 4'd3),   // R3
      vec(K_ERASE, 3'd3, 0, 0, 0, 1, 0, 0, 4'd3),   // R3
      vec(K_UNPROT,3'd3, 0, 0, 0, 1, 0, 0, 4'd5),   // R5
      vec(K_QUERY, 3'd3, 0, 0, 0, 0, 1, 1, 4'd5),   // R5
      vec(K_PROG,  3'd3, 1, 0, 1, 0, 0, 0, 4'd6),   // R6
      vec(K_ERASE, 3'd3, 1, 0, 1, 0, 0, 0, 4'd6),   // R6
      vec(K_QUERY, 3'd3, 0, 0, 0, 0, 1, 1, 4'd6),   // R6
      vec(K_ERASE, 3'd3, 0, 0, 0, 1, 0, 0, 4'd6),   // R6
      vec(K_PROG,  3'd4, 0, 1, 0, 0, 0, 0, 4'd7),   // R7
      vec(K_PROT,  3'd4, 0, 1, 0, 0, 0, 0, 4'd7),   // R7
      vec(K_QUERY, 3'd4, 0, 0, 0, 0, 1, 0, 4'd7),   // R7
      vec(K_PROT,  3'd0, 0, 0, 1, 0, 0, 0, 4'd4),   // R4
      vec(K_PROT,  3'd1, 0, 0, 1, 0, 0, 0, 4'd4),   // R4
      vec(K_PROT,  3'd2, 0, 0, 1, 0, 0, 0, 4'd4),   // R4
      vec(K_PROT,  3'd3, 0, 0, 1, 0, 0, 0, 4'd4),   // R4
      vec(K_PROT,  3'd4, 0, 0, 1, 0, 0, 0, 4'd4),   // R4
      vec(K_PROT,  3'd5, 0, 0, 1, 0, 0, 0, 4'd4),   // R4
      vec(K_PROT,  3'd6, 0, 0, 1, 0, 0, 0, 4'd4),   // R4
      vec(K_PROT,  3'd7, 0, 0, 1, 0, 0, 0, 4'd4),   // R4
      vec(K_UNPROT,3'd2, 0, 0, 1, 0, 0, 0, 4'd5),   // R5
      vec(K_QUERY, 3'd2, 0, 0, 0, 0, 1, 0, 4'd5),   // R5
      vec(K_QUERY, 3'd6, 0, 0, 0, 0, 1, 1, 4'd8),   // R8
      vec(K_UNPROT,3'd6, 0, 0, 0, 1, 0, 0, 4'd5),   // R5
      vec(K_ERASE, 3'd2, 0, 0, 1, 0, 0, 0, 4'd2),   // R2
      vec(K_ERASE, 3'd6, 0, 0, 0, 1, 0, 0, 4'd3),   // R3
      vec(K_UNPROT,3'd6, 0, 1, 0, 0, 0, 0, 4'd7),   // R7
      vec(K_QUERY, 3'd6, 0, 0, 0, 0, 1, 1, 4'd7)    // R7
   };

   task automatic step();
      @(posedge clk);
      #1ns;
   endtask

   task automatic chk(input string req, input string what,
                      input logic [7:0] act, input logic [7:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic idle_all();
      prog = 0; erase = 0; prot = 0; unprot = 0; query = 0; hv = 0; vlow = 0;
   endtask

   task automatic count_busy(input string req, input int exp_len);
      int n = 0;
      while (!ready && n < 100) begin
         n++;
         step();
      end
      chk(req, "busy length", 8'(n), 8'(exp_len));
   endtask

   initial begin
      #500us;
      nerr++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
   end

   initial begin
      repeat (3) step();
      // R1 reset state
      chk("R1", "ready", 8'(ready), 8'd1);
      chk("R1", "grant", 8'(grant), 8'd0);
      chk("R1", "deny", 8'(deny), 8'd0);
      chk("R1", "svld", 8'(svld), 8'd0);
      por_n = 1'b1;
      step();

      for (int i = 0; i < NV; i++) begin
         logic [15:0] e;
         string rq;
         e = VT[i];
         rq = $sformatf("R%0d", e[3:0]);
         sec = e[12:10];
         hv = e[9];
         vlow = e[8];
         prog   = (e[15:13] == K_PROG);
         erase  = (e[15:13] == K_ERASE);
         prot   = (e[15:13] == K_PROT);
         unprot = (e[15:13] == K_UNPROT);
         query  = (e[15:13] == K_QUERY);
         step();
         idle_all();
         chk(rq, "grant", 8'(grant), 8'(e[7]));
         chk(rq, "deny", 8'(deny), 8'(e[6]));
         chk(rq, "svld", 8'(svld), 8'(e[5]));
         chk(rq, "stat", stat, (e[5] && e[4]) ? 8'h01 : 8'h00);
         repeat (OPC + 2) step();
      end

      // R2: busy interval length; sector 2 is the only unprotected sector now
      sec = 3'd2; prog = 1;
      step(); idle_all();
      chk("R2", "grant", 8'(grant), 8'd1);
      count_busy("R2", OPC);
      chk("R2", "grant single pulse", 8'(grant), 8'd0);

      // R9: write strobe while busy is denied and changes nothing
      prog = 1;
      step(); idle_all();
      chk("R9", "grant", 8'(grant), 8'd1);
      prot = 1;
      step(); idle_all();
      chk("R9", "deny", 8'(deny), 8'd1);
      chk("R9", "grant", 8'(grant), 8'd0);
      repeat (OPC + 2) step();
      query = 1;
      step(); idle_all();
      chk("R9", "stat after busy protect", stat, 8'h00);

      // R10: device reset during an operation
      prog = 1;
      step(); idle_all();
      chk("R10", "grant", 8'(grant), 8'd1);
      dev_rst = 1;
      step(); dev_rst = 0;
      count_busy("R10", RBC);
      repeat (RRC + 2) step();

      // R10/R11: device reset while idle with a protect strobe and query
      dev_rst = 1; prot = 1; query = 1;
      step(); idle_all(); dev_rst = 0;
      chk("R10", "ready idle reset", 8'(ready), 8'd1);
      chk("R10", "grant under reset", 8'(grant), 8'd0);
      chk("R10", "deny under reset", 8'(deny), 8'd0);
      chk("R11", "svld under reset", 8'(svld), 8'd0);
      for (int k = 0; k < RRC; k++) begin
         query = 1;
         step(); query = 0;
         chk("R11", "svld in recovery", 8'(svld), 8'd0);
         chk("R11", "stat in recovery", stat, 8'h00);
      end
      query = 1;
      step(); query = 0;
      chk("R11", "svld after recovery", 8'(svld), 8'd1);
      chk("R10", "protect ignored under reset", stat, 8'h00);

      // R4: protect and query in the same cycle
      step();
      prot = 1; query = 1;
      step(); idle_all();
      chk("R4", "grant", 8'(grant), 8'd1);
      chk("R4", "svld", 8'(svld), 8'd1);
      chk("R4", "stat same cycle", stat, 8'h00);
      query = 1;
      step(); idle_all();
      chk("R4", "stat next cycle", stat, 8'h01);

      // R12: priority among simultaneous strobes (all sectors protected now)
      step();
      erase = 1; unprot = 1;
      step(); idle_all();
      chk("R12", "erase wins, denied", 8'(deny), 8'd1);
      chk("R12", "grant", 8'(grant), 8'd0);
      query = 1;
      step(); idle_all();
      chk("R12", "unprotect not served", stat, 8'h01);
      prot = 1; unprot = 1;
      step(); idle_all();
      chk("R12", "protect wins, granted", 8'(grant), 8'd1);
      query = 1;
      step(); idle_all();
      chk("R12", "sector still protected", stat, 8'h01);

      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
   end
endmodule